// File: doc/BRIEF.md
# Programmable AND Array with Uneven Product-Term Allocation

This block is the two-level logic core of a small programmable logic device. Twenty logic signals enter it: eleven fixed inputs, one pin that can serve either as a clock or as a further input, and eight feedback lines returned from the output macrocells. Each signal is offered to the array in true and in complement form, which gives forty array lines. Ninety product terms each form the AND of whichever lines a configuration vector connects to them.

Eighty of the terms are OR-ed into eight sum outputs. The outer two outputs at each end receive twelve terms each, and the four middle outputs receive eight each. Eight further terms act as per-output enables. The last two terms form a global preset and a global reset that every macrocell register shares.

The block has no state. The registers, output polarity and pin drivers sit in the macrocells downstream. A single configuration bit marks the clock/input pin as a clock, and its array lines then drop out of every term.

Top module: `pal_and_array`

## Requirements
- R1: Signal s feeds array line 2s in true form and line 2s+1 in complement form. Signals 0 to 10 are `fixed_in[0..10]`, signal 11 is `pin_in`, and signals 12 to 19 are `fb_in[0..7]`.
- R2: Term t uses configuration bits `fuse_map[40t+39:40t]`. Bit 40t+L set to 1 connects line L to the term. The term is the AND of all its connected lines.
- R3: A term with no connected line evaluates to 1.
- R4: A term that connects both the true and the complement line of one unmasked signal evaluates to 0. A term with every fuse set to 1 (the erased state) therefore evaluates to 0.
- R5: `sum_out[k]` is the OR of a contiguous block of terms. Terms are taken in rows from 0 upward, with 12, 12, 8, 8, 8, 8, 12 and 12 terms for k = 0 to 7. The blocks therefore start at rows 0, 12, 24, 32, 40, 48, 56 and 68, and no row below 80 affects any other output.
- R6: Row 80+k drives `oe_out[k]` alone, for k = 0 to 7.
- R7: Row 88 drives `preset_out` and row 89 drives `reset_out`. Each is a single signal shared by all outputs.
- R8: While `pin_is_clock` is 1, lines 22 and 23 (the pin's lines) are treated as unconnected in every term, whatever their fuse bits hold. While `pin_is_clock` is 0, the pin acts as an ordinary input.
- R9: Every output is a purely combinational function of the current inputs and the configuration. No earlier value has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fixed_in | input | 11 | Dedicated logic inputs, signals 0 to 10 |
| pin_in | input | 1 | Clock/input pin value, signal 11 |
| fb_in | input | 8 | Macrocell feedback lines, signals 12 to 19 |
| pin_is_clock | input | 1 | 1 removes the pin's lines from the array |
| fuse_map | input | 3600 | Connection bits, 40 per term, term 0 in the lowest bits |
| sum_out | output | 8 | OR of each output's product terms |
| oe_out | output | 8 | Per-output enable terms |
| preset_out | output | 1 | Global preset term |
| reset_out | output | 1 | Global reset term |

## Verification
The immediate checks in the checker take for granted that every input and every configuration bit holds a known 0 or 1. They also assume each change reaches all outputs before the checks are read, since the block is combinational. The stimulus drives only two-state values. It changes the configuration and the inputs just after a rising clock edge and reads the outputs at the following falling edge, so every evaluation is seen after the values have settled. The random configurations are kept sparse, about one connection in sixteen, so that terms evaluate to both 1 and 0 and do not sit at 0.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int NUM_FIXED = 11;
  localparam int NUM_OUT   = 8;
  localparam int PIN_SIG   = NUM_FIXED;
  localparam int NUM_SIG   = NUM_FIXED + 1 + NUM_OUT;
  localparam int NUM_LINE  = 2 * NUM_SIG;

  // product terms OR-ed into each output, output 0 first
  localparam int TERMS_PER_OUT [NUM_OUT] = '{12, 12, 8, 8, 8, 8, 12, 12};

  function automatic int sum_base(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (i < k) acc += TERMS_PER_OUT[i];
    end
    return acc;
  endfunction

  localparam int NUM_SUM_TERMS = sum_base(NUM_OUT);
  localparam int OE_BASE       = NUM_SUM_TERMS;
  localparam int PRESET_ROW    = OE_BASE + NUM_OUT;
  localparam int RESET_ROW     = PRESET_ROW + 1;
  localparam int NUM_TERMS     = RESET_ROW + 1;
  localparam int FUSE_BITS     = NUM_TERMS * NUM_LINE;

endpackage

// File: rtl/pal_line_drv.sv
// Builds the array lines. A line at 1 lets a connected term pass,
// so a signal that is masked drives both of its lines to 1.
module pal_line_drv #(
  parameter int NUM_FIXED = 11,
  parameter int NUM_OUT   = 8,
  localparam int NUM_SIG  = NUM_FIXED + 1 + NUM_OUT,
  localparam int NUM_LINE = 2 * NUM_SIG
) (
  input  logic [NUM_FIXED-1:0] fixed_in,
  input  logic                 pin_in,
  input  logic [NUM_OUT-1:0]   fb_in,
  input  logic                 pin_is_clock,
  output logic [NUM_LINE-1:0]  lines
);

  logic [NUM_SIG-1:0] sig;
  logic [NUM_SIG-1:0] masked;

  assign sig = {fb_in, pin_in, fixed_in};

  always_comb begin
    masked = '0;
    masked[NUM_FIXED] = pin_is_clock;
  end

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    assign lines[2*s]   = masked[s] | sig[s];
    assign lines[2*s+1] = masked[s] | ~sig[s];
  end

endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int NUM_LINE = 40
) (
  input  logic [NUM_LINE-1:0] row_fuse,
  input  logic [NUM_LINE-1:0] lines,
  output logic                term
);

  // an unconnected line contributes a 1 to the AND
  assign term = &(~row_fuse | lines);

endmodule

// File: rtl/pal_or_sum.sv
module pal_or_sum #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] terms,
  output logic             sum
);

  assign sum = |terms;

endmodule

// File: rtl/pal_and_array.sv
module pal_and_array
  import pal_pkg::*;
#(
  parameter int N_FIXED = pal_pkg::NUM_FIXED,
  parameter int N_OUT   = pal_pkg::NUM_OUT,
  localparam int N_LINE = 2 * (N_FIXED + 1 + N_OUT),
  localparam int N_FUSE = pal_pkg::NUM_TERMS * N_LINE
) (
  input  logic [N_FIXED-1:0] fixed_in,
  input  logic               pin_in,
  input  logic [N_OUT-1:0]   fb_in,
  input  logic               pin_is_clock,
  input  logic [N_FUSE-1:0]  fuse_map,
  output logic [N_OUT-1:0]   sum_out,
  output logic [N_OUT-1:0]   oe_out,
  output logic               preset_out,
  output logic               reset_out
);

  logic [N_LINE-1:0]    lines;
  logic [NUM_TERMS-1:0] term_vec;

  pal_line_drv #(
    .NUM_FIXED (N_FIXED),
    .NUM_OUT   (N_OUT)
  ) u_lines (
    .fixed_in     (fixed_in),
    .pin_in       (pin_in),
    .fb_in        (fb_in),
    .pin_is_clock (pin_is_clock),
    .lines        (lines)
  );

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    pal_pterm #(
      .NUM_LINE (N_LINE)
    ) u_pterm (
      .row_fuse (fuse_map[t*N_LINE +: N_LINE]),
      .lines    (lines),
      .term     (term_vec[t])
    );
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int BASE = sum_base(k);
    localparam int CNT  = TERMS_PER_OUT[k];

    pal_or_sum #(
      .WIDTH (CNT)
    ) u_sum (
      .terms (term_vec[BASE +: CNT]),
      .sum   (sum_out[k])
    );

    assign oe_out[k] = term_vec[OE_BASE + k];
  end

  assign preset_out = term_vec[PRESET_ROW];
  assign reset_out  = term_vec[RESET_ROW];

endmodule

// File: rtl/pal_and_array_chk.sv
module pal_and_array_chk
  import pal_pkg::*;
(
  input logic [NUM_FIXED-1:0] fixed_in,
  input logic                 pin_in,
  input logic [NUM_OUT-1:0]   fb_in,
  input logic                 pin_is_clock,
  input logic [FUSE_BITS-1:0] fuse_map,
  input logic [NUM_OUT-1:0]   sum_out,
  input logic [NUM_OUT-1:0]   oe_out,
  input logic                 preset_out,
  input logic                 reset_out
);

  localparam logic [NUM_LINE-1:0] PIN_BITS =
    {{(NUM_LINE-2){1'b0}}, 2'b11} << (2 * PIN_SIG);
  localparam logic [NUM_LINE-1:0] FIX0_TRUE = {{(NUM_LINE-1){1'b0}}, 1'b1};

  logic [NUM_LINE-1:0] rst_row;
  logic [NUM_LINE-1:0] pre_row;
  logic                all_erased;

  assign rst_row = fuse_map[RESET_ROW*NUM_LINE +: NUM_LINE];
  assign pre_row = fuse_map[PRESET_ROW*NUM_LINE +: NUM_LINE];

  always_comb begin
    for (int k = 0; k < NUM_OUT; k++) begin
      // R3
      if (fuse_map[(OE_BASE+k)*NUM_LINE +: NUM_LINE] == '0)
        blank_oe_high_chk: assert (oe_out[k] == 1'b1)
          else $error("blank enable term %0d not high", k);

      // R6
      if (fuse_map[(OE_BASE+k)*NUM_LINE +: NUM_LINE] ==
          (FIX0_TRUE << (2*(NUM_FIXED+1+k))))
        oe_follows_fb_chk: assert (oe_out[k] == fb_in[k])
          else $error("enable %0d does not follow its feedback", k);

      // R4
      all_erased = 1'b1;
      for (int r = sum_base(k); r < sum_base(k) + TERMS_PER_OUT[k]; r++)
        if (fuse_map[r*NUM_LINE +: NUM_LINE] != '1) all_erased = 1'b0;
      if (all_erased)
        erased_sum_low_chk: assert (sum_out[k] == 1'b0)
          else $error("erased output %0d not low", k);
    end

    // R7
    if (preset_out)
      preset_no_clash_chk: assert (!(pre_row[0] && pre_row[1]))
        else $error("preset high with contradicting fuses on signal 0");

    // R1
    if (rst_row == FIX0_TRUE)
      reset_follows_input_chk: assert (reset_out == fixed_in[0])
        else $error("reset term does not follow fixed input 0");

    // R8
    if (pin_is_clock && ((rst_row & ~PIN_BITS) == '0))
      clock_pin_masked_chk: assert (reset_out == 1'b1)
        else $error("clock pin lines not masked");

    // R8
    if (!pin_is_clock && (rst_row == (FIX0_TRUE << (2*PIN_SIG))))
      pin_as_input_chk: assert (reset_out == pin_in)
        else $error("pin not usable as input");
  end

endmodule

bind pal_and_array pal_and_array_chk u_chk (
  .fixed_in     (fixed_in),
  .pin_in       (pin_in),
  .fb_in        (fb_in),
  .pin_is_clock (pin_is_clock),
  .fuse_map     (fuse_map),
  .sum_out      (sum_out),
  .oe_out       (oe_out),
  .preset_out   (preset_out),
  .reset_out    (reset_out)
);

// File: tb/pal_and_array_bench.sv
module pal_and_array_bench;
  import pal_pkg::*;

  logic                 clk;
  logic [NUM_FIXED-1:0] fixed_in;
  logic                 pin_in;
  logic [NUM_OUT-1:0]   fb_in;
  logic                 pin_is_clock;
  logic [FUSE_BITS-1:0] fuse_map;
  logic [NUM_OUT-1:0]   sum_out;
  logic [NUM_OUT-1:0]   oe_out;
  logic                 preset_out;
  logic                 reset_out;

  int n_tests;
  int n_fail;
  int cycles;
  bit done;

  int alloc [8] = '{12, 12, 8, 8, 8, 8, 12, 12};

  pal_and_array u_pal_and_array (
    .fixed_in     (fixed_in),
    .pin_in       (pin_in),
    .fb_in        (fb_in),
    .pin_is_clock (pin_is_clock),
    .fuse_map     (fuse_map),
    .sum_out      (sum_out),
    .oe_out       (oe_out),
    .preset_out   (preset_out),
    .reset_out    (reset_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        n_fail++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  function automatic logic sig_val(input int s);
    if (s < 11) return fixed_in[s];
    if (s == 11) return pin_in;
    return fb_in[s-12];
  endfunction

  function automatic logic ref_term(input int t);
    logic r;
    r = 1'b1;
    for (int s = 0; s < 20; s++) begin
      if (!(pin_is_clock && s == 11)) begin
        if (fuse_map[t*40 + 2*s]     && !sig_val(s)) r = 1'b0;
        if (fuse_map[t*40 + 2*s + 1] &&  sig_val(s)) r = 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check_ref(input string req);
    logic [7:0] es;
    logic [7:0] eo;
    logic ep;
    logic er;
    int row;
    row = 0;
    es = '0;
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < alloc[k]; j++) begin
        if (ref_term(row)) es[k] = 1'b1;
        row++;
      end
    end
    for (int k = 0; k < 8; k++) eo[k] = ref_term(80 + k);
    ep = ref_term(88);
    er = ref_term(89);
    n_tests++;
    if (sum_out !== es || oe_out !== eo || preset_out !== ep || reset_out !== er) begin
      n_fail++;
      $display("FAIL %s: actual sum=%h oe=%h pre=%b rst=%b expected sum=%h oe=%h pre=%b rst=%b",
               req, sum_out, oe_out, preset_out, reset_out, es, eo, ep, er);
    end
  endtask

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic to_drive();
    @(posedge clk);
  endtask

  task automatic to_sample();
    @(negedge clk);
  endtask

  task automatic rand_inputs();
    fixed_in = NUM_FIXED'($urandom);
    pin_in   = 1'($urandom);
    fb_in    = NUM_OUT'($urandom);
  endtask

  task automatic clear_row(input int t);
    fuse_map[t*40 +: 40] = '0;
  endtask

  initial begin
    n_tests = 0;
    n_fail = 0;
    done = 1'b0;
    fixed_in = '0;
    pin_in = 1'b0;
    fb_in = '0;
    pin_is_clock = 1'b0;
    fuse_map = '1;

    // R4: erased device drives every output low
    for (int i = 0; i < 4; i++) begin
      to_drive();
      rand_inputs();
      to_sample();
      check_val("R4 erased outputs", {14'b0, preset_out, reset_out, oe_out, sum_out}, 32'h0);
      check_ref("R4 erased reference");
    end

    // R3: no connection anywhere gives all terms high
    to_drive();
    fuse_map = '0;
    rand_inputs();
    to_sample();
    check_val("R3 blank outputs", {14'b0, preset_out, reset_out, oe_out, sum_out}, 32'h3FFFF);

    // R4 / R7: contradiction on signal 3 in the preset row only
    to_drive();
    fuse_map = '0;
    fuse_map[88*40 + 6] = 1'b1;
    fuse_map[88*40 + 7] = 1'b1;
    to_sample();
    check_val("R4 preset contradiction", {31'b0, preset_out}, 32'h0);
    check_val("R7 reset unaffected", {31'b0, reset_out}, 32'h1);

    // R5: allocation boundaries, one blank row at a time
    begin
      int rows [11] = '{0, 11, 12, 23, 24, 31, 32, 55, 56, 67, 68};
      int outs [11] = '{0, 0, 1, 1, 2, 2, 3, 5, 6, 6, 7};
      for (int i = 0; i < 11; i++) begin
        to_drive();
        fuse_map = '1;
        clear_row(rows[i]);
        rand_inputs();
        to_sample();
        check_val($sformatf("R5 row %0d", rows[i]), {24'b0, sum_out}, 32'(1) << outs[i]);
        check_val("R6 enables idle", {24'b0, oe_out}, 32'h0);
      end
      to_drive();
      fuse_map = '1;
      clear_row(79);
      to_sample();
      check_val("R5 row 79", {24'b0, sum_out}, 32'h80);
    end

    // R6: each enable row reaches only its own output
    for (int k = 0; k < 8; k++) begin
      to_drive();
      fuse_map = '1;
      clear_row(80 + k);
      to_sample();
      check_val($sformatf("R6 enable %0d", k), {24'b0, oe_out}, 32'(1) << k);
      check_val("R5 sums idle", {24'b0, sum_out}, 32'h0);
    end

    // R7: reset row alone
    to_drive();
    fuse_map = '1;
    clear_row(89);
    to_sample();
    check_val("R7 reset only", {30'b0, preset_out, reset_out}, 32'h1);

    // R1: line order, feedback 2 true and fixed input 5 complement
    for (int v = 0; v < 4; v++) begin
      to_drive();
      fuse_map = '1;
      clear_row(0);
      fuse_map[0*40 + 28] = 1'b1;
      clear_row(12);
      fuse_map[12*40 + 11] = 1'b1;
      fb_in = '0;
      fb_in[2] = v[0];
      fixed_in = '1;
      fixed_in[5] = v[1];
      to_sample();
      check_val("R1 line order", {30'b0, sum_out[1], sum_out[0]}, {30'b0, ~v[1], v[0]});
    end

    // R8: pin lines masked in clock mode, live otherwise
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        to_drive();
        fuse_map = '1;
        clear_row(88);
        fuse_map[88*40 + 22] = 1'b1;
        pin_is_clock = m[0];
        pin_in = p[0];
        to_sample();
        check_val($sformatf("R8 mode %0d pin %0d", m, p), {31'b0, preset_out},
                  m[0] ? 32'h1 : {31'b0, p[0]});
      end
    end
    to_drive();
    fuse_map = '1;
    pin_is_clock = 1'b1;
    to_sample();
    check_val("R8 erased still low", {31'b0, preset_out}, 32'h0);
    pin_is_clock = 1'b0;

    // R2 / R9: sparse random configurations against the reference
    for (int n = 0; n < 150; n++) begin
      to_drive();
      for (int b = 0; b < FUSE_BITS; b++) fuse_map[b] = ($urandom_range(0, 15) == 0);
      pin_is_clock = ($urandom_range(0, 3) == 0);
      for (int v = 0; v < 4; v++) begin
        if (v != 0) to_drive();
        rand_inputs();
        to_sample();
        check_ref("R2 random map");
      end
      // R9: returning to an earlier input gives the earlier result
      to_drive();
      fixed_in = '0;
      pin_in = 1'b0;
      fb_in = '0;
      to_sample();
      check_ref("R9 no memory");
    end

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule